// File: doc/BRIEF.md
# I2C Four-Address Slave Matcher

This block is the address-recognition front end of an I2C slave. It brings the open-drain SCL and SDA lines into the local clock domain through synchronizers and detects start and stop conditions. After every start it shifts in the first byte and compares that byte with four programmable slave IDs, all at the same time. When an ID matches, the block raises an addressed flag. It also reports which ID matched and the direction bit of the transfer, and it asks the pad to pull SDA low during the ninth clock as the acknowledge.

Once a slave is addressed it stays active through the following bytes until a stop condition. This block does not handle those data bytes. A slave that is not addressed stays dormant until the next start condition. The four IDs are loaded through a simple write port, and that port only takes effect while no transfer is in progress on the bus.

Top module: `i2c_quad_addr_slave`

## Requirements
- R1: After reset, `addressed` and `ackPull` are 0, and all four IDs are 0x00.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop clears `addressed` and returns the block to idle.
- R3: After a start, eight address bits are sampled on SCL rising edges, MSB first. The byte matches an ID when bits 7:1 of the byte equal bits 7:1 of that ID. Bit 0 of an ID plays no part in the comparison.
- R4: When the byte matches, `readDir` equals the received bit 0 (1 means read) and `addressed` is 1.
- R5: When several IDs match, `matchIdx` reports the lowest-numbered one.
- R6: On a match, `ackPull` rises at the SCL falling edge that ends the eighth bit. It falls at the SCL falling edge that ends the ninth bit. `ackPull` is never 1 unless `addressed` is 1.
- R7: When no ID matches, there is no acknowledge and `addressed` stays 0 for the rest of the transfer, including any later bytes, until the next start.
- R8: When idle, a pulse on `idWrEn` writes `idWrData` into ID number `idWrSel`. Between a start and the following stop, ID writes are ignored.
- R9: A repeated start clears `addressed` and starts address capture again from the first bit.
- R10: An addressed slave keeps `addressed`, `matchIdx` and `readDir` through later bytes until a stop. It does not pull SDA during the ninth clock of those bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level (asynchronous) |
| sdaIn | input | 1 | SDA line level (asynchronous) |
| idWrEn | input | 1 | ID write strobe |
| idWrSel | input | IDX_W (2) | Which ID to write |
| idWrData | input | 8 | New ID value |
| addressed | output | 1 | Slave was addressed in the current transfer |
| matchIdx | output | IDX_W (2) | Index of the matching ID |
| readDir | output | 1 | Direction bit of the address byte |
| ackPull | output | 1 | Request to pull SDA low (acknowledge) |

## Verification
The assertions assume that each level on SCL and SDA is held for longer than the synchronizer depth plus one clock. Under that assumption every bus edge appears as exactly one event. They also assume that SDA changes only while SCL is low, except at start and stop conditions. The bench holds every bus level for six clocks and changes SDA only while SCL is low, apart from its start and stop sequences. It models the wired-AND line by combining the master's SDA with the block's `ackPull`.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
  localparam int ADDR_BITS = 8;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEv_t;

  typedef struct packed {
    logic shiftEn;
    logic evalEn;
    logic clearHit;
  } ctlStb_t;
endpackage

// File: rtl/i2c_match_dp.sv
module i2c_match_dp
  import i2c_match_pkg::*;
#(
  parameter int NUM_IDS     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NUM_IDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 idWrEn,
  input  logic [IDX_W-1:0]     idWrSel,
  input  logic [ADDR_BITS-1:0] idWrData,
  input  logic                 busy,
  input  ctlStb_t              stb,
  output busEv_t               ev,
  output logic                 hitQ,
  output logic [IDX_W-1:0]     matchIdxQ,
  output logic                 dirQ
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.start   = sclS && sclPrev && sdaPrev && !sdaS;
    ev.stop    = sclS && sclPrev && !sdaPrev && sdaS;
    ev.sclRise = sclS && !sclPrev;
    ev.sclFall = !sclS && sclPrev;
  end

  logic [NUM_IDS-1:0][ADDR_BITS-1:0] idRegs;
  logic [ADDR_BITS-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idRegs <= '0;
    end else if (idWrEn && !busy) begin
      idRegs[idWrSel] <= idWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else if (stb.shiftEn) shiftQ <= {shiftQ[ADDR_BITS-2:0], sdaS};
  end

  logic [NUM_IDS-1:0] hitVec;
  for (genvar gi = 0; gi < NUM_IDS; gi++) begin : g_cmp
    assign hitVec[gi] = (idRegs[gi][ADDR_BITS-1:1] == shiftQ[ADDR_BITS-1:1]);
  end

  logic [IDX_W-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ      <= 1'b0;
      matchIdxQ <= '0;
      dirQ      <= 1'b0;
    end else if (stb.clearHit) begin
      hitQ <= 1'b0;
    end else if (stb.evalEn) begin
      hitQ      <= |hitVec;
      matchIdxQ <= firstIdx;
      dirQ      <= shiftQ[0];
    end
  end

  assert_id_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (idWrEn && busy) |=> $stable(idRegs));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ && !stb.evalEn) |=> $stable(matchIdxQ) && $stable(dirQ));
endmodule

// File: rtl/i2c_match_ctl.sv
module i2c_match_ctl
  import i2c_match_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEv_t  ev,
  input  logic    hitIn,
  output ctlStb_t stb,
  output logic    busy,
  output logic    ackPull
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_EVAL, S_WAITF, S_ACK, S_ACTIVE, S_DORMANT
  } state_t;

  localparam int CNT_W = $clog2(ADDR_BITS);

  state_t stateQ, stateD;
  logic [CNT_W-1:0] bitCntQ, bitCntD;

  always_comb begin
    stateD  = stateQ;
    bitCntD = bitCntQ;
    if (ev.stop) begin
      stateD = S_IDLE;
    end else if (ev.start) begin
      stateD  = S_ADDR;
      bitCntD = '0;
    end else begin
      unique case (stateQ)
        S_ADDR: if (ev.sclRise) begin
          bitCntD = bitCntQ + 1'b1;
          if (bitCntQ == CNT_W'(ADDR_BITS - 1)) stateD = S_EVAL;
        end
        S_EVAL:  stateD = S_WAITF;
        S_WAITF: if (ev.sclFall) stateD = hitIn ? S_ACK : S_DORMANT;
        S_ACK:   if (ev.sclFall) stateD = S_ACTIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      bitCntQ <= '0;
    end else begin
      stateQ  <= stateD;
      bitCntQ <= bitCntD;
    end
  end

  always_comb begin
    stb.shiftEn  = (stateQ == S_ADDR) && ev.sclRise && !ev.start && !ev.stop;
    stb.evalEn   = (stateQ == S_EVAL) && !ev.start && !ev.stop;
    stb.clearHit = ev.start || ev.stop;
  end

  assign busy    = (stateQ != S_IDLE);
  assign ackPull = (stateQ == S_ACK);

  assert_ack_needs_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackPull |-> hitIn);

  assert_ack_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackPull) |-> $past(ev.sclFall));

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> !hitIn && !busy);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    ev.start |=> !hitIn && !ackPull);
endmodule

// File: rtl/i2c_quad_addr_slave.sv
module i2c_quad_addr_slave
  import i2c_match_pkg::*;
#(
  parameter int NUM_IDS     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NUM_IDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             idWrEn,
  input  logic [IDX_W-1:0] idWrSel,
  input  logic [7:0]       idWrData,
  output logic             addressed,
  output logic [IDX_W-1:0] matchIdx,
  output logic             readDir,
  output logic             ackPull
);
  busEv_t  ev;
  ctlStb_t stb;
  logic    busy, hitQ;

  i2c_match_dp #(.NUM_IDS(NUM_IDS), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .idWrEn(idWrEn), .idWrSel(idWrSel), .idWrData(idWrData),
    .busy(busy), .stb(stb), .ev(ev),
    .hitQ(hitQ), .matchIdxQ(matchIdx), .dirQ(readDir)
  );

  i2c_match_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .hitIn(hitQ),
    .stb(stb), .busy(busy), .ackPull(ackPull)
  );

  assign addressed = hitQ;
endmodule

// File: tb/test_i2c_quad_addr_slave.sv
module test_i2c_quad_addr_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic idWrEn = 1'b0;
  logic [1:0] idWrSel = '0;
  logic [7:0] idWrData = '0;
  logic addressed, readDir, ackPull;
  logic [1:0] matchIdx;
  logic sdaLine;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  assign sdaLine = sdaDrv & ~ackPull;

  i2c_quad_addr_slave i_i2c_quad_addr_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .idWrEn(idWrEn), .idWrSel(idWrSel), .idWrData(idWrData),
    .addressed(addressed), .matchIdx(matchIdx), .readDir(readDir), .ackPull(ackPull)
  );

  // {address byte, expected hit, expected index, expected direction}
  localparam logic [11:0] VEC [8] = '{
    {8'hA2, 1'b1, 2'd1, 1'b0},  // R5: IDs 1 and 2 both match
    {8'hA3, 1'b1, 2'd1, 1'b1},
    {8'h50, 1'b1, 2'd0, 1'b0},
    {8'h51, 1'b1, 2'd0, 1'b1},  // R3: ID bit 0 ignored
    {8'h3D, 1'b1, 2'd3, 1'b1},
    {8'h3C, 1'b1, 2'd3, 1'b0},
    {8'h12, 1'b0, 2'd0, 1'b0},
    {8'hFE, 1'b0, 2'd0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (6) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; hold();
    sclDrv = 1'b1; hold();
    sdaDrv = 1'b0; hold();
    sclDrv = 1'b0; hold();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; hold();
    sclDrv = 1'b1; hold();
    sdaDrv = 1'b1; hold();
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b;    hold();
    sclDrv = 1'b1; hold();
    sclDrv = 1'b0; hold();
  endtask

  task automatic sendByte(input logic [7:0] b, input int expAck, input string tag);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    chk({tag, " ack after 8th bit"}, int'(ackPull), expAck);
    sdaDrv = 1'b1; hold();
    sclDrv = 1'b1; hold();
    chk({tag, " ack in 9th clock"}, int'(ackPull), expAck);
    chk({tag, " sda line in 9th clock"}, int'(sdaLine), 1 - expAck);
    sclDrv = 1'b0; hold();
    chk({tag, " ack released"}, int'(ackPull), 0);
  endtask

  task automatic writeId(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    idWrSel = sel; idWrData = val; idWrEn = 1'b1;
    @(negedge clk);
    idWrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 addressed in reset", int'(addressed), 0);
    rstN = 1'b1;
    hold();
    chk("R1 addressed after reset", int'(addressed), 0);
    chk("R1 ackPull after reset", int'(ackPull), 0);

    // R1: IDs reset to 0x00, so address 0x01 matches ID 0
    busStart();
    sendByte(8'h01, 1, "R1 reset ID");
    chk("R1 reset ID index", int'(matchIdx), 0);
    busStop();
    chk("R2 stop clears", int'(addressed), 0);

    // R8: idle writes
    writeId(2'd0, 8'h50);
    writeId(2'd1, 8'hA3);
    writeId(2'd2, 8'hA2);
    writeId(2'd3, 8'h3C);

    for (int v = 0; v < 8; v++) begin
      busStart();
      chk("R2 start leaves unaddressed", int'(addressed), 0);
      sendByte(VEC[v][11:4], int'(VEC[v][3]), "R6 address");
      chk("R3 addressed", int'(addressed), int'(VEC[v][3]));
      if (VEC[v][3]) begin
        chk("R5 matchIdx", int'(matchIdx), int'(VEC[v][2:1]));
        chk("R4 readDir", int'(readDir), int'(VEC[v][0]));
      end
      // a data byte that looks like a matching address must not wake a dormant slave
      sendByte(8'h50, 0, "R7 R10 data byte");
      chk("R7 R10 addressed through data", int'(addressed), int'(VEC[v][3]));
      if (VEC[v][3]) chk("R10 index held", int'(matchIdx), int'(VEC[v][2:1]));
      busStop();
      chk("R2 stop clears addressed", int'(addressed), 0);
    end

    // R8: write during a transfer is ignored
    busStart();
    sendByte(8'h12, 0, "R8 miss");
    writeId(2'd3, 8'h12);
    busStop();
    busStart();
    sendByte(8'h12, 0, "R8 write ignored");
    chk("R8 write ignored", int'(addressed), 0);
    busStop();
    writeId(2'd3, 8'h12);
    busStart();
    sendByte(8'h13, 1, "R8 idle write");
    chk("R8 idle write index", int'(matchIdx), 3);
    chk("R8 idle write dir", int'(readDir), 1);
    busStop();

    // R9: repeated start after a miss, then after a hit
    busStart();
    sendByte(8'hFE, 0, "R9 first miss");
    busStart();
    sendByte(8'h50, 1, "R9 restart hit");
    chk("R9 restart index", int'(matchIdx), 0);
    busStart();
    chk("R9 restart clears", int'(addressed), 0);
    sendByte(8'hFE, 0, "R9 restart miss");
    chk("R9 restart miss", int'(addressed), 0);
    busStop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule